// File: doc/BRIEF.md
# Replicated Register Steering Bank

This block holds one copy of a small register file for each hardware unit in a grid of groups and instances. All copies share one word address space. A separate selector register chooses the target unit and a multicast flag, and that selector alone decides which copy an access reaches. A write can reach every copy at once or only the steered one. A read always returns exactly one copy: the steered one.

Each unit has a bit in an availability mask, driven from outside, that marks units which are fused off or power-gated. An access steered to an unavailable unit is terminated. A read returns zero and a write changes nothing. The stored contents of that unit stay as they were. A semaphore register lets several agents take turns using the selector. An init input forces the semaphore back to free.

The bus side is a single valid/ready port. It always accepts, and it returns read data one cycle after a read is accepted.

Top module: `repl_steer_bank`

## Requirements
- R1: After reset every stored copy reads zero, the selector reads zero, and the semaphore is free.
- R2: The selector lives at word address 0x20. It holds the group number in bits [3:0], the instance number in bits [11:8] and the multicast flag in bit 16. A read of the selector returns those fields with all other bits zero.
- R3: A write to a replicated address 0..7 with the multicast flag set stores the data into that address of every available unit.
- R4: A multicast write leaves the copies of unavailable units unchanged.
- R5: With the multicast flag clear, a write to a replicated address changes only the copy of unit (group*4 + instance).
- R6: A unicast write steered to an unavailable unit has no effect on any copy.
- R7: A read of a replicated address returns the steered unit's copy, whether or not the multicast flag is set.
- R8: A read steered to an unavailable unit returns zero. The stored value becomes visible again once the unit is available.
- R9: A group number of 4 or more, or an instance number of 4 or more, steers to no unit. Reads return zero and unicast writes change nothing.
- R10: A read of the semaphore at address 0x21 returns 1 and takes it when it is free. While it is taken, reads return 0. A write of zero frees it, and a nonzero write is ignored.
- R11: Asserting lock_clear for one cycle leaves the semaphore free. This takes precedence over a read in the same cycle.
- R12: req_ready is always high. rsp_valid rises for exactly the cycle after each accepted read and never after a write.
- R13: A read of any address outside 0..7, 0x20 and 0x21 returns zero, and a write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_clear | input | 1 | Forces the semaphore to the free state |
| unit_enable | input | NUM_GROUPS*NUM_INST | Availability per unit; bit group*NUM_INST+instance |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |

## Verification
Directed cases each isolate one steering rule:
- a multicast write with one unit masked, read back from several units (R3, R4);
- unicast writes to a live unit, a masked unit and out-of-range numbers, each followed by reads of the neighbouring units (R5, R6, R9);
- a read with the multicast flag set (R7);
- masking and then unmasking the same unit, to tell termination apart from erasure (R8).

A seeded random phase mixes the following against a reference model, so that stale steering or leaking writes show up as mismatches:
- selector writes with junk in the unused bits;
- unicast and multicast writes;
- changes to the availability mask;
- semaphore traffic.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
   // selector field layout
   localparam int FIELD_W       = 4;
   localparam int GROUP_LSB     = 0;
   localparam int INST_LSB      = 8;
   localparam int MCAST_BIT     = 16;

   typedef struct packed {
      logic               mcast;
      logic [FIELD_W-1:0] inst;
      logic [FIELD_W-1:0] group;
   } steer_sel_t;

   typedef enum logic [1:0] {
      TGT_REPL = 2'd0,
      TGT_SEL  = 2'd1,
      TGT_LOCK = 2'd2,
      TGT_NONE = 2'd3
   } target_e;

   function automatic steer_sel_t sel_unpack(input logic [31:0] w);
      steer_sel_t s;
      s.group = w[GROUP_LSB +: FIELD_W];
      s.inst  = w[INST_LSB +: FIELD_W];
      s.mcast = w[MCAST_BIT];
      return s;
   endfunction

   function automatic logic [31:0] sel_pack(input steer_sel_t s);
      logic [31:0] w;
      w = '0;
      w[GROUP_LSB +: FIELD_W] = s.group;
      w[INST_LSB +: FIELD_W]  = s.inst;
      w[MCAST_BIT]            = s.mcast;
      return w;
   endfunction
endpackage

// File: rtl/rsb_selector.sv
module rsb_selector
   import rsb_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_INST   = 4,
   parameter int DATA_W     = 32,
   localparam int NUM_UNITS = NUM_GROUPS * NUM_INST,
   localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] sel_word,
   output logic              mcast,
   output logic [UNIT_W-1:0] steer_unit,
   output logic              steer_ok
);
   steer_sel_t sel_q;
   logic [31:0] wide_in;
   logic [31:0] wide_out;

   assign wide_in = 32'(wdata);

   // R1 reset clears, R2 fields captured
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel_q <= '0;
      else if (wr_en) sel_q <= sel_unpack(wide_in);
   end

   assign wide_out = sel_pack(sel_q);
   assign sel_word = DATA_W'(wide_out);
   assign mcast    = sel_q.mcast;

   // R9 range check and unit index
   always_comb begin
      int g;
      int i;
      int u;
      g = int'(sel_q.group);
      i = int'(sel_q.inst);
      steer_ok   = (g < NUM_GROUPS) && (i < NUM_INST);
      u          = steer_ok ? (g * NUM_INST + i) : 0;
      steer_unit = UNIT_W'(u);
   end
endmodule

// File: rtl/rsb_storage.sv
module rsb_storage #(
   parameter int NUM_UNITS = 16,
   parameter int NUM_REGS  = 8,
   parameter int DATA_W    = 32,
   localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 mcast,
   input  logic [UNIT_W-1:0]    steer_unit,
   input  logic                 steer_ok,
   input  logic [REG_W-1:0]     reg_idx,
   input  logic [NUM_UNITS-1:0] unit_enable,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rd_data
);
   logic [DATA_W-1:0]    unit_word [NUM_UNITS];
   logic [NUM_UNITS-1:0] unit_hit;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic [DATA_W-1:0] mem_q [NUM_REGS];
      logic              target;

      // R3/R5: multicast reaches all, unicast only the steered unit
      assign target      = mcast | (steer_ok & (steer_unit == UNIT_W'(u)));
      // R4/R6: an unavailable unit never takes a write
      assign unit_hit[u] = wr_en & unit_enable[u] & target;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
         end else if (unit_hit[u]) begin
            mem_q[reg_idx] <= wdata;
         end
      end

      assign unit_word[u] = mem_q[reg_idx];
   end

   // R7 single steered copy, R8/R9 termination to zero
   always_comb begin
      rd_data = '0;
      if (steer_ok && unit_enable[steer_unit]) rd_data = unit_word[steer_unit];
   end
endmodule

// File: rtl/rsb_lock.sv
module rsb_lock #(
   parameter bit HAS_LOCK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   input  logic wr_en,
   input  logic wdata_zero,
   input  logic force_free,
   output logic grant,
   output logic held
);
   if (HAS_LOCK) begin : g_lock
      logic held_q;
      // R10 take on read, release on zero write; R11 force wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   held_q <= 1'b0;
         else if (force_free)          held_q <= 1'b0;
         else if (rd_en)               held_q <= 1'b1;
         else if (wr_en && wdata_zero) held_q <= 1'b0;
      end
      assign grant = ~held_q;
      assign held  = held_q;
   end else begin : g_nolock
      logic unused;
      assign unused = clk ^ rst_n ^ rd_en ^ wr_en ^ wdata_zero ^ force_free;
      assign grant  = 1'b0;
      assign held   = 1'b0;
   end
endmodule

// File: rtl/repl_steer_bank.sv
module repl_steer_bank
   import rsb_pkg::*;
#(
   parameter int              NUM_GROUPS = 4,
   parameter int              NUM_INST   = 4,
   parameter int              NUM_REGS   = 8,
   parameter int              DATA_W     = 32,
   parameter int              ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] SEL_ADDR  = 'h20,
   parameter logic [ADDR_W-1:0] LOCK_ADDR = 'h21,
   parameter bit              HAS_LOCK   = 1'b1,
   localparam int NUM_UNITS = NUM_GROUPS * NUM_INST,
   localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lock_clear,
   input  logic [NUM_UNITS-1:0] unit_enable,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 rsp_valid,
   output logic [DATA_W-1:0]    rsp_rdata
);
   // elaboration-time parameter checks
   if (NUM_GROUPS < 1 || NUM_GROUPS > (1 << FIELD_W)) begin : g_bad_groups
      $error("NUM_GROUPS out of range for selector field");
   end
   if (NUM_INST < 1 || NUM_INST > (1 << FIELD_W)) begin : g_bad_inst
      $error("NUM_INST out of range for selector field");
   end
   if (DATA_W < MCAST_BIT + 1) begin : g_bad_width
      $error("DATA_W too narrow for selector layout");
   end
   if (NUM_REGS < 2 || NUM_REGS > int'(SEL_ADDR) || NUM_REGS > int'(LOCK_ADDR)) begin : g_bad_regs
      $error("replicated range overlaps control addresses");
   end
   if (SEL_ADDR == LOCK_ADDR) begin : g_bad_map
      $error("selector and lock share an address");
   end

   target_e             tgt;
   logic                acc_rd;
   logic                acc_wr;
   logic [REG_W-1:0]    reg_idx;
   logic [DATA_W-1:0]   sel_word;
   logic                mcast;
   logic [UNIT_W-1:0]   steer_unit;
   logic                steer_ok;
   logic [DATA_W-1:0]   repl_rdata;
   logic                lock_grant;
   logic                lock_held;
   logic [DATA_W-1:0]   rd_mux;

   // R12: always accepting
   assign req_ready = 1'b1;
   assign acc_rd    = req_valid & ~req_write;
   assign acc_wr    = req_valid &  req_write;
   assign reg_idx   = req_addr[REG_W-1:0];

   // R13 address decode
   always_comb begin
      if (req_addr < ADDR_W'(NUM_REGS)) tgt = TGT_REPL;
      else if (req_addr == SEL_ADDR)    tgt = TGT_SEL;
      else if (req_addr == LOCK_ADDR)   tgt = TGT_LOCK;
      else                              tgt = TGT_NONE;
   end

   rsb_selector #(
      .NUM_GROUPS(NUM_GROUPS),
      .NUM_INST  (NUM_INST),
      .DATA_W    (DATA_W)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (acc_wr && tgt == TGT_SEL),
      .wdata     (req_wdata),
      .sel_word  (sel_word),
      .mcast     (mcast),
      .steer_unit(steer_unit),
      .steer_ok  (steer_ok)
   );

   rsb_storage #(
      .NUM_UNITS(NUM_UNITS),
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (acc_wr && tgt == TGT_REPL),
      .mcast      (mcast),
      .steer_unit (steer_unit),
      .steer_ok   (steer_ok),
      .reg_idx    (reg_idx),
      .unit_enable(unit_enable),
      .wdata      (req_wdata),
      .rd_data    (repl_rdata)
   );

   rsb_lock #(
      .HAS_LOCK(HAS_LOCK)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (acc_rd && tgt == TGT_LOCK),
      .wr_en     (acc_wr && tgt == TGT_LOCK),
      .wdata_zero(req_wdata == '0),
      .force_free(lock_clear),
      .grant     (lock_grant),
      .held      (lock_held)
   );

   always_comb begin
      unique case (tgt)
         TGT_REPL: rd_mux = repl_rdata;
         TGT_SEL:  rd_mux = sel_word;
         TGT_LOCK: rd_mux = DATA_W'(lock_grant);
         default:  rd_mux = '0;
      endcase
   end

   // R12 registered response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc_rd;
         if (acc_rd) rsp_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
   parameter int              NUM_UNITS = 16,
   parameter int              NUM_REGS  = 8,
   parameter int              DATA_W    = 32,
   parameter int              ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] SEL_ADDR  = 'h20,
   parameter logic [ADDR_W-1:0] LOCK_ADDR = 'h21,
   localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 rsp_valid,
   input logic [DATA_W-1:0]    rsp_rdata,
   input logic [NUM_UNITS-1:0] unit_enable,
   input logic                 lock_clear,
   input logic [UNIT_W-1:0]    steer_unit,
   input logic                 steer_ok,
   input logic                 lock_held,
   input logic [DATA_W-1:0]    sel_word
);
   logic rd_acc;
   logic rd_repl;
   logic rd_other;
   logic live;

   assign rd_acc   = req_valid && !req_write;
   assign rd_repl  = rd_acc && (req_addr < ADDR_W'(NUM_REGS));
   assign rd_other = rd_acc && !(req_addr < ADDR_W'(NUM_REGS))
                     && req_addr != SEL_ADDR && req_addr != LOCK_ADDR;
   assign live     = steer_ok && unit_enable[steer_unit];

   assert_rsp_only_reads_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(rd_acc));

   assert_read_answered_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> rsp_valid);

   assert_terminated_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_repl && !live) |=> (rsp_rdata == '0));

   assert_selector_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && req_addr == SEL_ADDR) |=> $stable(sel_word));

   assert_force_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_clear |=> !lock_held);

   assert_taken_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && req_addr == LOCK_ADDR && lock_held) |=> (rsp_rdata == '0));

   assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_other |=> (rsp_rdata == '0));
endmodule

bind repl_steer_bank rsb_checker #(
   .NUM_UNITS(NUM_GROUPS * NUM_INST),
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .SEL_ADDR (SEL_ADDR),
   .LOCK_ADDR(LOCK_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_rdata  (rsp_rdata),
   .unit_enable(unit_enable),
   .lock_clear (lock_clear),
   .steer_unit (steer_unit),
   .steer_ok   (steer_ok),
   .lock_held  (lock_held),
   .sel_word   (sel_word)
);

// File: tb/sim_repl_steer_bank.sv
`timescale 1ns/1ps
module sim_repl_steer_bank;
   localparam int NG = 4;
   localparam int NI = 4;
   localparam int NU = NG * NI;
   localparam int NR = 8;
   localparam logic [7:0] SEL = 8'h20;
   localparam logic [7:0] LCK = 8'h21;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          lock_clear;
   logic [NU-1:0] en;
   logic          req_valid;
   logic          req_ready;
   logic          req_write;
   logic [7:0]    req_addr;
   logic [31:0]   req_wdata;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;

   int checks = 0;
   int errors = 0;

   logic [31:0] mdl [NU][NR];
   logic [3:0]  mg, mi;
   logic        mmc;
   logic        mlock;

   always #2 clk = ~clk;

   repl_steer_bank u0 (
      .clk(clk), .rst_n(rst_n), .lock_clear(lock_clear), .unit_enable(en),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

   function automatic logic [31:0] sel_f();
      return {15'b0, mmc, 4'b0, mi, 4'b0, mg};
   endfunction

   function automatic bit in_range();
      return (int'(mg) < NG) && (int'(mi) < NI);
   endfunction

   function automatic bit live();
      return in_range() && en[int'(mg) * NI + int'(mi)];
   endfunction

   function automatic logic [31:0] exp_repl(int r);
      return live() ? mdl[int'(mg) * NI + int'(mi)][r] : 32'h0;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic apply_wr(logic [7:0] a, logic [31:0] d);
      if (int'(a) < NR) begin
         if (mmc) begin
            for (int u = 0; u < NU; u++) if (en[u]) mdl[u][a] = d;
         end else if (live()) begin
            mdl[int'(mg) * NI + int'(mi)][a] = d;
         end
      end else if (a == SEL) begin
         mg = d[3:0]; mi = d[11:8]; mmc = d[16];
      end else if (a == LCK) begin
         if (d == 32'h0) mlock = 1'b0;
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 no response after write", 32'(rsp_valid), 32'h0);
      apply_wr(a, d);
   endtask

   task automatic rd(logic [7:0] a, string tag);
      logic [31:0] exp;
      if (int'(a) < NR)  exp = exp_repl(int'(a));
      else if (a == SEL) exp = sel_f();
      else if (a == LCK) begin exp = {31'b0, ~mlock}; mlock = 1'b1; end
      else               exp = 32'h0;
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = $urandom;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 response valid after read", 32'(rsp_valid), 32'h1);
      chk(tag, rsp_rdata, exp);
   endtask

   task automatic steer(int g, int i, bit mc);
      wr(SEL, (32'(mc) << 16) | (32'(i) << 8) | 32'(g));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; lock_clear = 1'b0; en = '1;
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      for (int u = 0; u < NU; u++) for (int r = 0; r < NR; r++) mdl[u][r] = '0;
      mg = '0; mi = '0; mmc = 1'b0; mlock = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R12 ready
      chk("R12 ready high", 32'(req_ready), 32'h1);
      rd(SEL, "R1 selector reset");
      rd(8'd3, "R1 copy reset");
      rd(LCK, "R1 lock free after reset");
      wr(LCK, 32'h0);

      // R2 selector field layout
      wr(SEL, 32'hFFFF_FFFF);
      rd(SEL, "R2 selector readback");

      // R3 / R4 multicast with unit 5 masked
      en = '1; en[5] = 1'b0;
      steer(0, 0, 1'b1);
      wr(8'd2, 32'hA5A5_0001);
      steer(0, 0, 1'b0); rd(8'd2, "R3 multicast unit 0");
      steer(1, 3, 1'b0); rd(8'd2, "R3 multicast unit 7");
      steer(3, 3, 1'b0); rd(8'd2, "R3 multicast unit 15");
      en[5] = 1'b1;
      steer(1, 1, 1'b0); rd(8'd2, "R4 masked unit kept old value");

      // R5 unicast
      steer(2, 3, 1'b0); wr(8'd4, 32'h0000_1234);
      steer(2, 2, 1'b0); rd(8'd4, "R5 neighbour untouched");
      steer(2, 3, 1'b0); rd(8'd4, "R5 steered copy written");

      // R6 unicast to masked unit
      en[9] = 1'b0;
      steer(2, 1, 1'b0); wr(8'd4, 32'hDEAD_BEEF);
      rd(8'd4, "R8 masked read zero");
      en[9] = 1'b1;
      rd(8'd4, "R6 masked write dropped");

      // R7 read with multicast flag set
      steer(2, 3, 1'b1); rd(8'd4, "R7 multicast read single copy");

      // R8 termination keeps contents
      en[11] = 1'b0; rd(8'd4, "R8 gated read zero");
      en[11] = 1'b1; rd(8'd4, "R8 value preserved");

      // R9 out of range steering
      steer(4, 0, 1'b0); wr(8'd1, 32'h0000_0077);
      rd(8'd1, "R9 group out of range read");
      steer(0, 5, 1'b0); wr(8'd1, 32'h0000_0078);
      rd(8'd1, "R9 instance out of range read");
      steer(0, 0, 1'b0); rd(8'd1, "R9 no copy written");
      steer(3, 3, 1'b0); rd(8'd1, "R9 no copy written");

      // R10 semaphore
      rd(LCK, "R10 first reader granted");
      rd(LCK, "R10 second reader refused");
      wr(LCK, 32'h5);
      rd(LCK, "R10 nonzero write ignored");
      wr(LCK, 32'h0);
      rd(LCK, "R10 granted after release");

      // R11 force release
      lock_clear = 1'b1;
      @(negedge clk);
      lock_clear = 1'b0;
      mlock = 1'b0;
      rd(LCK, "R11 free after force");
      wr(LCK, 32'h0);

      // R13 unmapped addresses
      rd(8'h40, "R13 unmapped read zero");
      rd(8'h08, "R13 unmapped read zero");
      wr(8'h40, 32'hFFFF_FFFF);
      wr(8'h22, 32'h0);
      rd(SEL, "R13 unmapped write no effect");

      // random phase
      for (int n = 0; n < 900; n++) begin
         int op;
         op = int'($urandom_range(0, 99));
         if (op < 20) begin
            int g, i;
            logic [31:0] w;
            g = int'($urandom_range(0, 4));
            i = int'($urandom_range(0, 4));
            w = ($urandom & ~32'h0001_0F0F) | (32'(g) | (32'(i) << 8));
            if ($urandom_range(0, 3) == 0) w[16] = 1'b1; else w[16] = 1'b0;
            wr(SEL, w);
            if (op < 5) rd(SEL, "R2 random selector readback");
         end else if (op < 50) begin
            wr(8'($urandom_range(0, NR - 1)), $urandom);
         end else if (op < 85) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, NR - 1));
            if (!in_range())    rd(a, "R9 random out of range read");
            else if (!live())   rd(a, "R8 random masked read");
            else if (mmc)       rd(a, "R7 random read with multicast");
            else                rd(a, "R5 random unicast read");
         end else if (op < 92) begin
            en = NU'($urandom | $urandom);
            @(negedge clk);
         end else if (op < 97) begin
            rd(LCK, "R10 random lock read");
         end else begin
            wr(LCK, 32'h0);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule